// File: doc/BRIEF.md
# Aperture Address Remapper

This block sits on the address path between a DMA-capable device and memory. A 1 MB window of the physical address space, called the aperture, is remapped page by page. Each 4 KB page in the window has one entry in a flat table held in on-chip registers. An entry holds a valid flag and a target page number. A request inside the window takes its page number from the entry and keeps its page offset. A request inside the window whose entry is not valid is refused with an error. A request outside the window goes out unchanged and is not checked.

The block therefore moves device traffic around memory but does not protect memory from the device. The window position comes from a base register written as a frame number, so the window is always aligned to its own size. Software fills the table through a single-entry write port. Every request gets its result exactly one cycle after it is issued.

Top module: `apt_remap`

## Requirements
- R1: After reset (rst_ni low), rsp_valid_o, rsp_err_o and rsp_xlat_o are 0. Every table entry is invalid. The window frame is BASE_RST, which defaults to 0.
- R2: When req_valid_i is 1 in a cycle, rsp_valid_o is 1 in the next cycle. When req_valid_i is 0, rsp_valid_o is 0 in the next cycle.
- R3: A request whose bits [31:20] differ from the window frame comes out with rsp_addr_o equal to req_addr_i, rsp_err_o 0 and rsp_xlat_o 0.
- R4: A request inside the window whose entry is valid comes out with rsp_addr_o = {entry page number, req_addr_i[11:0]}, rsp_xlat_o 1 and rsp_err_o 0.
- R5: A request inside the window whose entry is invalid comes out with rsp_err_o 1, rsp_xlat_o 0 and rsp_addr_o 0.
- R6: The table index is req_addr_i[19:12], which equals the address minus the window base, shifted right by 12.
- R7: The window covers exactly the addresses whose bits [31:20] equal base_frame_i as written. The first and last bytes of the window are translated. The bytes just below and just above the window pass through unchanged.
- R8: A table write (tbl_we_i) in cycle t is seen by requests issued from cycle t+1 onward. A request issued in cycle t still sees the old entry. The write can either set the entry valid or clear it.
- R9: A base write (base_we_i) in cycle t moves the window for requests issued from cycle t+1 onward. A request issued in cycle t still uses the old frame.
- R10: While rsp_valid_o is 0, rsp_err_o and rsp_xlat_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | ADDR_W | Device address |
| rsp_valid_o | output | 1 | Result present, one cycle after the request |
| rsp_addr_o | output | ADDR_W | Outgoing address (0 on fault) |
| rsp_err_o | output | 1 | Request refused: the entry inside the window is invalid |
| rsp_xlat_o | output | 1 | Address was translated through the table |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_idx_i | input | IDX_W | Entry index to write |
| tbl_valid_i | input | 1 | Valid flag to store |
| tbl_page_i | input | ADDR_W-PAGE_W | Target page number to store |
| base_we_i | input | 1 | Window frame write strobe |
| base_frame_i | input | ADDR_W-PAGE_W-IDX_W | New window frame (address bits above the window) |

## Verification
The hardest case to produce is a request in the same cycle as a write that changes the answer to that very request. The request must still see the old state, and the request in the next cycle must see the new state. The bench drives a table write and a request to the same entry in the same cycle, then repeats the request in the next cycle. It does the same with a base write, so that one address moves from translated to pass-through and another address moves into the window. The window edges are hit with addresses one byte outside each side. An asynchronous reset in the middle of the run checks that the entries and the frame really return to their reset values.

// File: rtl/apt_remap_pkg.sv
package apt_remap_pkg;
  localparam int unsigned ADDR_W_DEF  = 32;
  localparam int unsigned PAGE_W_DEF  = 12;
  localparam int unsigned ENTRIES_DEF = 256;

  typedef enum logic [1:0] {
    KIND_PASS  = 2'd0,
    KIND_XLAT  = 2'd1,
    KIND_FAULT = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/apt_window_decode.sv
module apt_window_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned WIN_W   = PAGE_W + IDX_W,
  localparam int unsigned FRAME_W = ADDR_W - WIN_W,
  localparam int unsigned PN_W    = ADDR_W - PAGE_W
) (
  input  logic [PN_W-1:0]    page_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               in_win_o,
  output logic [IDX_W-1:0]   idx_o
);
  // base is size-aligned: subtract-and-shift reduces to slicing
  assign in_win_o = (page_i[PN_W-1:IDX_W] == frame_i);
  assign idx_o    = page_i[IDX_W-1:0];
endmodule

// File: rtl/apt_page_table.sv
module apt_page_table #(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned PN_W    = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             wvalid_i,
  input  logic [PN_W-1:0]  wpage_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic             rvalid_o,
  output logic [PN_W-1:0]  rpage_o
);
  logic            valid_q [ENTRIES];
  logic [PN_W-1:0] page_q  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        page_q[g]  <= '0;
      end else if (we_i && (widx_i == IDX_W'(g))) begin
        valid_q[g] <= wvalid_i;
        page_q[g]  <= wpage_i;
      end
    end
  end

  // read sees registered state: same-cycle writes land after this request
  assign rvalid_o = valid_q[ridx_i];
  assign rpage_o  = page_q[ridx_i];
endmodule

// File: rtl/apt_resp_reg.sv
module apt_resp_reg
  import apt_remap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  rsp_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              err_o,
  output logic              xlat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      err_o   <= 1'b0;
      xlat_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o <= addr_i;
        err_o  <= (kind_i == KIND_FAULT);
        xlat_o <= (kind_i == KIND_XLAT);
      end else begin
        addr_o <= '0;
        err_o  <= 1'b0;
        xlat_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/apt_remap.sv
module apt_remap
  import apt_remap_pkg::*;
#(
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned PAGE_W   = PAGE_W_DEF,
  parameter int unsigned ENTRIES  = ENTRIES_DEF,
  parameter int unsigned BASE_RST = 0,
  localparam int unsigned IDX_W   = $clog2(ENTRIES),
  localparam int unsigned WIN_W   = PAGE_W + IDX_W,
  localparam int unsigned FRAME_W = ADDR_W - WIN_W,
  localparam int unsigned PN_W    = ADDR_W - PAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               rsp_valid_o,
  output logic [ADDR_W-1:0]  rsp_addr_o,
  output logic               rsp_err_o,
  output logic               rsp_xlat_o,
  input  logic               tbl_we_i,
  input  logic [IDX_W-1:0]   tbl_idx_i,
  input  logic               tbl_valid_i,
  input  logic [PN_W-1:0]    tbl_page_i,
  input  logic               base_we_i,
  input  logic [FRAME_W-1:0] base_frame_i
);
  logic [FRAME_W-1:0] frame_q;
  logic               in_win;
  logic [IDX_W-1:0]   idx;
  logic               ent_valid;
  logic [PN_W-1:0]    ent_page;
  rsp_kind_e          kind;
  logic [ADDR_W-1:0]  addr_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        frame_q <= FRAME_W'(BASE_RST);
    else if (base_we_i) frame_q <= base_frame_i;
  end

  apt_window_decode #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .IDX_W  (IDX_W)
  ) u_dec (
    .page_i   (req_addr_i[ADDR_W-1:PAGE_W]),
    .frame_i  (frame_q),
    .in_win_o (in_win),
    .idx_o    (idx)
  );

  apt_page_table #(
    .ENTRIES (ENTRIES),
    .PN_W    (PN_W)
  ) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tbl_we_i),
    .widx_i   (tbl_idx_i),
    .wvalid_i (tbl_valid_i),
    .wpage_i  (tbl_page_i),
    .ridx_i   (idx),
    .rvalid_o (ent_valid),
    .rpage_o  (ent_page)
  );

  always_comb begin
    if (!in_win)        kind = KIND_PASS;
    else if (ent_valid) kind = KIND_XLAT;
    else                kind = KIND_FAULT;

    unique case (kind)
      KIND_PASS:  addr_nxt = req_addr_i;
      KIND_XLAT:  addr_nxt = {ent_page, req_addr_i[PAGE_W-1:0]};
      default:    addr_nxt = '0;
    endcase
  end

  apt_resp_reg #(
    .ADDR_W (ADDR_W)
  ) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .kind_i  (kind),
    .addr_i  (addr_nxt),
    .valid_o (rsp_valid_o),
    .addr_o  (rsp_addr_o),
    .err_o   (rsp_err_o),
    .xlat_o  (rsp_xlat_o)
  );
endmodule

// File: rtl/apt_remap_chk.sv
module apt_remap_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAGE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rsp_addr_o,
  input logic              rsp_err_o,
  input logic              rsp_xlat_o
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);  // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);  // R2
  AST_PASS_UNCHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_xlat_o && !rsp_err_o) |-> (rsp_addr_o == $past(req_addr_i)));  // R3
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_xlat_o) |->
      (rsp_addr_o[PAGE_W-1:0] == $past(req_addr_i[PAGE_W-1:0])));  // R4
  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_err_o && rsp_xlat_o));  // R5
  AST_FAULT_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_addr_o == '0));  // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_err_o && !rsp_xlat_o));  // R10
endmodule

bind apt_remap apt_remap_chk #(
  .ADDR_W (ADDR_W),
  .PAGE_W (PAGE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_addr_o  (rsp_addr_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_xlat_o  (rsp_xlat_o)
);

// File: tb/apt_remap_test.sv
module apt_remap_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_addr_o;
  logic        rsp_err_o;
  logic        rsp_xlat_o;
  logic        tbl_we_i = 1'b0;
  logic [7:0]  tbl_idx_i = '0;
  logic        tbl_valid_i = 1'b0;
  logic [19:0] tbl_page_i = '0;
  logic        base_we_i = 1'b0;
  logic [11:0] base_frame_i = '0;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  apt_remap uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .rsp_valid_o(rsp_valid_o), .rsp_addr_o(rsp_addr_o),
    .rsp_err_o(rsp_err_o), .rsp_xlat_o(rsp_xlat_o),
    .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i),
    .tbl_valid_i(tbl_valid_i), .tbl_page_i(tbl_page_i),
    .base_we_i(base_we_i), .base_frame_i(base_frame_i)
  );

  // {req addr, expected addr, expected err, expected xlat}; frame 12'h401
  localparam logic [65:0] VEC [9] = '{
    {32'h4010_0ABC, 32'h1234_5ABC, 1'b0, 1'b1},  // R4 idx 0
    {32'h401F_FFFF, 32'hABCD_EFFF, 1'b0, 1'b1},  // R7 last byte in window
    {32'h4020_0000, 32'h4020_0000, 1'b0, 1'b0},  // R7 just above
    {32'h400F_FFFF, 32'h400F_FFFF, 1'b0, 1'b0},  // R7 just below
    {32'h4010_5010, 32'h0007_7010, 1'b0, 1'b1},  // R6 idx 5
    {32'h4010_6000, 32'h0000_0000, 1'b1, 1'b0},  // R5 written invalid
    {32'h4010_7000, 32'h0000_0000, 1'b1, 1'b0},  // R5 never written
    {32'h0000_1234, 32'h0000_1234, 1'b0, 1'b0},  // R3
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0}   // R3
  };

  task automatic expect_rsp(input string tag, input logic v, input logic [31:0] a,
                            input logic e, input logic x);
    n_chk++;
    if (rsp_valid_o !== v || rsp_addr_o !== a || rsp_err_o !== e || rsp_xlat_o !== x) begin
      n_fail++;
      $display("FAIL %s: got v=%0b a=%h e=%0b x=%0b, expected v=%0b a=%h e=%0b x=%0b",
               tag, rsp_valid_o, rsp_addr_o, rsp_err_o, rsp_xlat_o, v, a, e, x);
    end
  endtask

  task automatic cycle();
    @(negedge clk_i);
    req_valid_i = 1'b0;
    tbl_we_i    = 1'b0;
    base_we_i   = 1'b0;
  endtask

  task automatic set_req(input logic [31:0] a);
    req_valid_i = 1'b1;
    req_addr_i  = a;
  endtask

  task automatic set_tbl(input logic [7:0] i, input logic v, input logic [19:0] p);
    tbl_we_i = 1'b1; tbl_idx_i = i; tbl_valid_i = v; tbl_page_i = p;
  endtask

  task automatic set_base(input logic [11:0] f);
    base_we_i = 1'b1; base_frame_i = f;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    expect_rsp("R1 reset outputs", 1'b0, 32'h0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    cycle();
    // R1: frame resets to 0, entries invalid -> fault
    set_req(32'h0000_0000); cycle();
    expect_rsp("R1 reset table invalid", 1'b1, 32'h0, 1'b1, 1'b0);

    set_base(12'h401);           cycle();
    set_tbl(8'd0,   1'b1, 20'h12345); cycle();
    set_tbl(8'd255, 1'b1, 20'hABCDE); cycle();
    set_tbl(8'd5,   1'b1, 20'h00077); cycle();
    set_tbl(8'd6,   1'b0, 20'h55555); cycle();

    for (int i = 0; i < 9; i++) begin
      set_req(VEC[i][65:34]);
      cycle();
      expect_rsp($sformatf("vector %0d (R3-R7)", i), 1'b1, VEC[i][33:2], VEC[i][1], VEC[i][0]);
    end
    cycle();
    expect_rsp("R2 no request no response", 1'b0, 32'h0, 1'b0, 1'b0);
    expect_rsp("R10 idle quiet", 1'b0, 32'h0, 1'b0, 1'b0);

    // R8: same-cycle write sees old entry, next cycle sees new
    set_tbl(8'd5, 1'b1, 20'h11111); set_req(32'h4010_5000); cycle();
    expect_rsp("R8 same-cycle old entry", 1'b1, 32'h0007_7000, 1'b0, 1'b1);
    set_req(32'h4010_5000); cycle();
    expect_rsp("R8 next-cycle new entry", 1'b1, 32'h1111_1000, 1'b0, 1'b1);
    set_tbl(8'd0, 1'b0, 20'h12345); cycle();
    set_req(32'h4010_0000); cycle();
    expect_rsp("R8 invalidated entry faults", 1'b1, 32'h0, 1'b1, 1'b0);

    // R9: base move
    set_base(12'h800); set_req(32'h4010_5000); cycle();
    expect_rsp("R9 same-cycle old frame", 1'b1, 32'h1111_1000, 1'b0, 1'b1);
    set_req(32'h4010_5000); cycle();
    expect_rsp("R9 old window now passes", 1'b1, 32'h4010_5000, 1'b0, 1'b0);
    set_req(32'h8000_5ABC); cycle();
    expect_rsp("R9 new window translates", 1'b1, 32'h1111_1ABC, 1'b0, 1'b1);

    // R1: asynchronous reset mid-run
    @(posedge clk_i); #2;
    rst_ni = 1'b0;
    @(negedge clk_i);
    expect_rsp("R1 async reset clears outputs", 1'b0, 32'h0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    cycle();
    set_req(32'h8000_5000); cycle();
    expect_rsp("R1 frame back to reset value", 1'b1, 32'h8000_5000, 1'b0, 1'b0);
    set_req(32'h0000_5000); cycle();
    expect_rsp("R1 entries cleared by reset", 1'b1, 32'h0, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule